// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small set of hardware lock flags that two independent agents, a left port and a right port, use to coordinate access to a shared resource. Each flag is free, held by the left port, or held by the right port. A port takes part only while its active-low select strobe is low. A 3-bit index picks the flag. The port then either writes one data bit or reads one status bit.

To claim a flag, a port writes 0 to it. It then reads the flag back: 0 means it holds the flag and 1 means it does not. Writing 1 gives the flag back, but only when the writer is the holder. If a claim arrives while the other side holds the flag, it is remembered. The flag then passes to the waiting port on the same clock edge at which the holder gives it back, unless the waiting port has withdrawn by writing 1 in the meantime. When both ports claim a free flag in the same cycle, the left port gets it.

Top module: `sema_bank`

## Requirements
- R1: The bank holds eight flags. An operation on one flag never changes the holder or the waiting state of any other flag.
- R2: A port whose select strobe (`*_sem_n`) is high has no effect on any flag, and its read data output holds its value.
- R3: The 3-bit index `*_sel` picks flag 0 to 7. Only that flag is read or written.
- R4: A write with data 0 to a free flag gives the flag to the writing port. Afterwards the holder reads 0 and the other port reads 1. A write with data 0 by the port that already holds the flag changes nothing.
- R5: A write with data 1 by the holder frees the flag. A write with data 1 by the other port does not change the holder.
- R6: A write with data 0 while the other port holds the flag makes the writer wait. When the holder frees the flag, the flag passes to the waiting port on that same edge, so the waiting port reads 0 from then on.
- R7: A write with data 1 by a waiting port withdraws its wait. A later release by the holder then leaves the flag free.
- R8: When both ports write 0 to the same free flag in one cycle, the left port gets the flag and the right port waits.
- R9: After a synchronous reset, every flag is free with nothing waiting, and both read data outputs are 1.
- R10: A read (strobe low, `*_we` low) updates that port's `*_rdata` on the next rising edge. The value is 0 if the port held the flag before that edge and 1 otherwise. In all other cycles `*_rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| l_sem_n | input | 1 | Left port select strobe, active low |
| l_we | input | 1 | Left port: 1 = write, 0 = read |
| l_sel | input | 3 | Left port flag index |
| l_wdata | input | 1 | Left port write bit (0 = claim, 1 = give back) |
| l_rdata | output | 1 | Left port registered read bit (0 = held by left) |
| r_sem_n | input | 1 | Right port select strobe, active low |
| r_we | input | 1 | Right port: 1 = write, 0 = read |
| r_sel | input | 3 | Right port flag index |
| r_wdata | input | 1 | Right port write bit (0 = claim, 1 = give back) |
| r_rdata | output | 1 | Right port registered read bit (0 = held by right) |

## Verification
The assertions assume that all inputs are known, and sampled without X, on every rising edge once reset has been released. They also assume that reset lasts at least one edge before any strobe is used. Nothing is assumed about how the two ports interact: same-index collisions, claims by the holder, give-backs by the non-holder and withdrawals are all legal. The stimulus drives every input to a defined value on each falling edge and keeps reset high for several cycles. It then mixes random operations, confined to a narrow index range so that the ports collide often, with directed sequences for the same-cycle tie, the pending hand-over and the withdrawal.

// File: rtl/sema_pkg.sv
package sema_pkg;

  typedef enum logic [1:0] {
    HOLD_NONE  = 2'd0,
    HOLD_LEFT  = 2'd1,
    HOLD_RIGHT = 2'd2
  } holder_t;

  typedef struct packed {
    logic claim;
    logic give;
  } flag_evt_t;

endpackage

// File: rtl/sema_port_decode.sv
module sema_port_decode #(
  parameter int NUM_FLAGS = 8,
  localparam int SEL_W = $clog2(NUM_FLAGS)
) (
  input  logic clk,
  input  logic rst,
  input  logic sem_n,
  input  logic we,
  input  logic [SEL_W-1:0] sel,
  input  logic wdata,
  output sema_pkg::flag_evt_t evt [NUM_FLAGS],
  output logic rd_strobe
);
  import sema_pkg::*;

  logic active_wr;
  assign active_wr = !sem_n && we;
  assign rd_strobe = !sem_n && !we;

  logic [NUM_FLAGS-1:0] claim_vec, give_vec;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_evt
    logic hit;
    assign hit = active_wr && (sel == SEL_W'(g));
    assign claim_vec[g] = hit && !wdata;
    assign give_vec[g]  = hit && wdata;
    assign evt[g].claim = claim_vec[g];
    assign evt[g].give  = give_vec[g];
  end

  AST_ONE_FLAG_TOUCHED: assert property (@(posedge clk) disable iff (rst)
    $onehot0(claim_vec | give_vec)); // R3
  AST_IDLE_WHEN_UNSELECTED: assert property (@(posedge clk) disable iff (rst)
    sem_n |-> ($countones(claim_vec | give_vec) == 0)); // R2

endmodule

// File: rtl/sema_cell.sv
module sema_cell (
  input  logic clk,
  input  logic rst,
  input  sema_pkg::flag_evt_t lev,
  input  sema_pkg::flag_evt_t rev,
  output logic held_l,
  output logic held_r
);
  import sema_pkg::*;

  holder_t holder_q, holder_d;
  logic wait_l_q, wait_l_d;
  logic wait_r_q, wait_r_d;

  always_comb begin
    holder_d = holder_q;
    wait_l_d = wait_l_q;
    wait_r_d = wait_r_q;
    unique case (holder_q)
      HOLD_NONE: begin
        if (lev.claim) begin
          holder_d = HOLD_LEFT;
          wait_r_d = rev.claim;
        end else if (rev.claim) begin
          holder_d = HOLD_RIGHT;
        end
      end
      HOLD_LEFT: begin
        if (rev.claim) wait_r_d = 1'b1;
        if (rev.give)  wait_r_d = 1'b0;
        if (lev.give) begin
          if ((wait_r_q || rev.claim) && !rev.give) holder_d = HOLD_RIGHT;
          else                                      holder_d = HOLD_NONE;
          wait_r_d = 1'b0;
        end
      end
      HOLD_RIGHT: begin
        if (lev.claim) wait_l_d = 1'b1;
        if (lev.give)  wait_l_d = 1'b0;
        if (rev.give) begin
          if ((wait_l_q || lev.claim) && !lev.give) holder_d = HOLD_LEFT;
          else                                      holder_d = HOLD_NONE;
          wait_l_d = 1'b0;
        end
      end
      default: begin
        holder_d = HOLD_NONE;
        wait_l_d = 1'b0;
        wait_r_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holder_q <= HOLD_NONE;
      wait_l_q <= 1'b0;
      wait_r_q <= 1'b0;
    end else begin
      holder_q <= holder_d;
      wait_l_q <= wait_l_d;
      wait_r_q <= wait_r_d;
    end
  end

  assign held_l = (holder_q == HOLD_LEFT);
  assign held_r = (holder_q == HOLD_RIGHT);

  AST_RESET_FREE: assert property (@(posedge clk)
    $past(rst) |-> (holder_q == HOLD_NONE && !wait_l_q && !wait_r_q)); // R9
  AST_TIE_LEFT_WINS: assert property (@(posedge clk) disable iff (rst)
    (holder_q == HOLD_NONE && lev.claim && rev.claim) |=> (holder_q == HOLD_LEFT && wait_r_q)); // R8
  AST_NO_STEAL_LEFT: assert property (@(posedge clk) disable iff (rst)
    (holder_q == HOLD_LEFT && !lev.give) |=> (holder_q == HOLD_LEFT)); // R5
  AST_NO_STEAL_RIGHT: assert property (@(posedge clk) disable iff (rst)
    (holder_q == HOLD_RIGHT && !rev.give) |=> (holder_q == HOLD_RIGHT)); // R5
  AST_WAIT_NEEDS_HOLDER: assert property (@(posedge clk) disable iff (rst)
    (wait_r_q |-> holder_q == HOLD_LEFT) and (wait_l_q |-> holder_q == HOLD_RIGHT)); // R6
  AST_HANDOVER_RIGHT: assert property (@(posedge clk) disable iff (rst)
    (holder_q == HOLD_LEFT && lev.give && wait_r_q && !rev.give) |=> (holder_q == HOLD_RIGHT)); // R6
  AST_WITHDRAW_LEFT: assert property (@(posedge clk) disable iff (rst)
    (holder_q == HOLD_RIGHT && lev.give) |=> !wait_l_q); // R7

endmodule

// File: rtl/sema_readout.sv
module sema_readout #(
  parameter int NUM_FLAGS = 8,
  localparam int SEL_W = $clog2(NUM_FLAGS)
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_strobe,
  input  logic [SEL_W-1:0] sel,
  input  logic [NUM_FLAGS-1:0] held_mine,
  output logic rdata
);

  always_ff @(posedge clk) begin
    if (rst)            rdata <= 1'b1;
    else if (rd_strobe) rdata <= ~held_mine[sel];
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rd_strobe |=> $stable(rdata)); // R10

endmodule

// File: rtl/sema_bank.sv
module sema_bank #(
  parameter int NUM_FLAGS = 8,
  localparam int SEL_W = $clog2(NUM_FLAGS)
) (
  input  logic clk,
  input  logic rst,
  input  logic l_sem_n,
  input  logic l_we,
  input  logic [SEL_W-1:0] l_sel,
  input  logic l_wdata,
  output logic l_rdata,
  input  logic r_sem_n,
  input  logic r_we,
  input  logic [SEL_W-1:0] r_sel,
  input  logic r_wdata,
  output logic r_rdata
);
  import sema_pkg::*;

  flag_evt_t l_evt [NUM_FLAGS];
  flag_evt_t r_evt [NUM_FLAGS];
  logic l_rd, r_rd;
  logic [NUM_FLAGS-1:0] held_l, held_r;

  sema_port_decode #(.NUM_FLAGS(NUM_FLAGS)) u_dec_l (
    .clk(clk), .rst(rst), .sem_n(l_sem_n), .we(l_we), .sel(l_sel),
    .wdata(l_wdata), .evt(l_evt), .rd_strobe(l_rd));

  sema_port_decode #(.NUM_FLAGS(NUM_FLAGS)) u_dec_r (
    .clk(clk), .rst(rst), .sem_n(r_sem_n), .we(r_we), .sel(r_sel),
    .wdata(r_wdata), .evt(r_evt), .rd_strobe(r_rd));

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    sema_cell u_cell (
      .clk(clk), .rst(rst), .lev(l_evt[g]), .rev(r_evt[g]),
      .held_l(held_l[g]), .held_r(held_r[g]));
  end

  sema_readout #(.NUM_FLAGS(NUM_FLAGS)) u_rd_l (
    .clk(clk), .rst(rst), .rd_strobe(l_rd), .sel(l_sel),
    .held_mine(held_l), .rdata(l_rdata));

  sema_readout #(.NUM_FLAGS(NUM_FLAGS)) u_rd_r (
    .clk(clk), .rst(rst), .rd_strobe(r_rd), .sel(r_sel),
    .held_mine(held_r), .rdata(r_rdata));

  AST_SINGLE_HOLDER: assert property (@(posedge clk) disable iff (rst)
    (held_l & held_r) == '0); // R1
  AST_RESET_READS_ONE: assert property (@(posedge clk)
    $past(rst) |-> (l_rdata && r_rdata)); // R9

endmodule

// File: tb/tb_sema_bank.sv
module tb_sema_bank;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l_sem_n = 1'b1, l_we = 1'b0, l_wdata = 1'b1;
  logic r_sem_n = 1'b1, r_we = 1'b0, r_wdata = 1'b1;
  logic [2:0] l_sel = '0, r_sel = '0;
  logic l_rdata, r_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  sema_bank dut (
    .clk(clk), .rst(rst),
    .l_sem_n(l_sem_n), .l_we(l_we), .l_sel(l_sel), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sem_n(r_sem_n), .r_we(r_we), .r_sel(r_sel), .r_wdata(r_wdata), .r_rdata(r_rdata));

  // bench model: 0 free, 1 left, 2 right
  int own [N];
  bit wl [N];
  bit wr [N];
  bit exp_l = 1'b1, exp_r = 1'b1;
  int checks = 0, fails = 0;

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  function automatic bit read_val(input int who, input int idx);
    return !(own[idx] == who);
  endfunction

  task automatic model_step(input bit la, input bit lw, input int ls, input bit ld,
                            input bit ra, input bit rw, input int rs, input bit rd);
    for (int i = 0; i < N; i++) begin
      bit lc, lg, rc, rg;
      lc = la && lw && ls == i && !ld;
      lg = la && lw && ls == i && ld;
      rc = ra && rw && rs == i && !rd;
      rg = ra && rw && rs == i && rd;
      case (own[i])
        0: if (lc) begin own[i] = 1; wr[i] = rc; end
           else if (rc) own[i] = 2;
        1: begin
          if (rc) wr[i] = 1;
          if (rg) wr[i] = 0;
          if (lg) begin own[i] = wr[i] ? 2 : 0; wr[i] = 0; end
        end
        default: begin
          if (lc) wl[i] = 1;
          if (lg) wl[i] = 0;
          if (rg) begin own[i] = wl[i] ? 1 : 0; wl[i] = 0; end
        end
      endcase
    end
  endtask

  task automatic cycle(input string req,
                       input bit la, input bit lw, input int ls, input bit ld,
                       input bit ra, input bit rw, input int rs, input bit rd);
    @(negedge clk);
    l_sem_n = !la; l_we = lw; l_sel = 3'(ls); l_wdata = ld;
    r_sem_n = !ra; r_we = rw; r_sel = 3'(rs); r_wdata = rd;
    if (la && !lw) exp_l = read_val(1, ls);
    if (ra && !rw) exp_r = read_val(2, rs);
    model_step(la, lw, ls, ld, ra, rw, rs, rd);
    @(posedge clk); #1;
    chk({req, " left"}, l_rdata, exp_l);
    chk({req, " right"}, r_rdata, exp_r);
  endtask

  task automatic idle_cycle(input string req);
    cycle(req, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin own[i] = 0; wl[i] = 0; wr[i] = 0; end
    repeat (4) @(posedge clk);
    #1;
    chk("R9 reset left", l_rdata, 1'b1);
    chk("R9 reset right", r_rdata, 1'b1);
    @(negedge clk); rst = 1'b0;
    // R9: every flag reads 1 from both sides
    for (int i = 0; i < N; i++) cycle("R9 free read", 1, 0, i, 0, 1, 0, i, 0);
    // R8: tie on flag 2, then R4 readback
    cycle("R8 tie", 1, 1, 2, 0, 1, 1, 2, 0);
    cycle("R8 R4 readback", 1, 0, 2, 0, 1, 0, 2, 0);
    chk("R8 left owns", l_rdata, 1'b0);
    chk("R8 right waits", r_rdata, 1'b1);
    // R1 R3: neighbours untouched
    cycle("R1 R3 neighbour", 1, 0, 3, 0, 1, 0, 1, 0);
    chk("R1 neighbour free", l_rdata, 1'b1);
    // R5: non-holder release ignored
    cycle("R5 foreign give", 0, 0, 0, 0, 1, 1, 5, 1);
    cycle("R5 setup", 1, 1, 5, 0, 0, 0, 0, 0);
    cycle("R5 foreign give", 0, 0, 0, 0, 1, 1, 5, 1);
    cycle("R5 still held", 1, 0, 5, 0, 1, 0, 5, 0);
    chk("R5 holder kept", l_rdata, 1'b0);
    // R6: flag 2 right waiting, left gives back
    cycle("R6 handover", 1, 1, 2, 1, 0, 0, 0, 0);
    cycle("R6 readback", 1, 0, 2, 0, 1, 0, 2, 0);
    chk("R6 right now holds", r_rdata, 1'b0);
    // R7: withdraw on flag 5
    cycle("R7 wait", 0, 0, 0, 0, 1, 1, 5, 0);
    cycle("R7 withdraw", 0, 0, 0, 0, 1, 1, 5, 1);
    cycle("R7 holder gives", 1, 1, 5, 1, 0, 0, 0, 0);
    cycle("R7 readback", 1, 0, 5, 0, 1, 0, 5, 0);
    chk("R7 flag free", r_rdata, 1'b1);
    // R2: unselected claim ignored
    @(negedge clk);
    l_sem_n = 1'b1; l_we = 1'b1; l_sel = 3'd6; l_wdata = 1'b0;
    @(posedge clk); #1;
    chk("R2 rdata held", l_rdata, exp_l);
    cycle("R2 flag stays free", 1, 0, 6, 0, 1, 0, 6, 0);
    chk("R2 free", l_rdata, 1'b1);
    idle_cycle("R10 hold");
    // random phase, narrow index range for collisions
    for (int k = 0; k < 4000; k++) begin
      bit la, lw, ld, ra, rw, rd;
      int ls, rs;
      la = ($urandom % 10) < 7; lw = $urandom % 2; ld = $urandom % 2;
      ra = ($urandom % 10) < 7; rw = $urandom % 2; rd = $urandom % 2;
      ls = (k < 2000) ? $urandom % 3 : $urandom % N;
      rs = (k < 2000) ? $urandom % 3 : $urandom % N;
      cycle("R4 R6 R10 random", la, lw, ls, ld, ra, rw, rs, rd);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule